// File: doc/BRIEF.md
# Dual-Channel UART Interrupt Front End

This block is the CPU-facing register layer of a two-channel serial port. Channel A serves the console and channel B the auxiliary line. It decodes single-cycle bus accesses into per-channel status, holding and command registers, plus one shared register. A write to the shared register loads the interrupt mask, and a read of it returns the interrupt status. Received-character events, character-available levels, received bytes and a periodic tick come in from the surrounding logic. The block keeps the interrupt status bits, gates new events with the mask, and drives one interrupt request line.

Transmit-ready interrupts are not raised per character. A tick divider raises both channels' transmit-ready status bits together on every second tick, and only when at least one transmit-ready mask bit is set. A holding-register write hands the byte to the line side on a one-cycle valid pulse. A command write with the transmitter-disable bit set produces a one-cycle flush request for that channel. Baud generation, serialisation and the counter/timer are out of scope.

Reads are combinational: `rdata_o` is valid in the same cycle as `req_i`. Every state change takes effect at the next rising clock edge.

Top module: `duart_irq_fe`

## Requirements
- R1: Interrupt status bit layout: bit 0 is TX-ready A, bit 1 is RX-ready A, bit 4 is TX-ready B and bit 5 is RX-ready B. All other bits read as zero. A write to the shared register (offset 0x2C) loads the 8-bit mask, and a read of it returns the status.
- R2: When `rx_arrive_i[c]` is high and mask bit 1 (A) or 5 (B) is set, the matching status bit is set and `irq_o` is high on the next cycle. With the mask bit clear, the arrival changes neither the status nor `irq_o`.
- R3: Status registers are at 0x0C (A) and 0x4C (B). They read bit 0 = `rx_avail_i[c]` and bit 2 = 1, with all other bits zero.
- R4: A read of status A with no interrupt-setting event in the same cycle drives `irq_o` low on the next cycle. A read of status B leaves `irq_o` unchanged.
- R5: Every second `tick_i` pulse counted since reset sets both status bits 0 and 4 and raises `irq_o`, but only if mask bit 0 or mask bit 4 is set. Odd-numbered ticks do nothing.
- R6: A read of holding register 0x1C (A) or 0x5C (B) returns `rx_data_a_i` or `rx_data_b_i`. It pulses `rx_pop_o[c]` in the same cycle and clears that channel's RX-ready status bit.
- R7: A write to a holding register drives `tx_valid_o[c]` high for one cycle, one cycle later, with `tx_data_o` equal to the written byte. It clears only that channel's TX-ready bit (bit 0 for A, bit 4 for B).
- R8: A write to command register 0x14 (A) or 0x54 (B) with data bit 3 set pulses `flush_o[c]` one cycle later. With bit 3 clear there is no pulse.
- R9: The mode registers (0x04, 0x44), aux control (0x24) and output-port registers (0x6C, 0x74, 0x7C) read as zero. Writes to them change no status, mask or output.
- R10: When a status bit is cleared and set in the same cycle, it ends set. An interrupt-setting event in the same cycle as a status A read leaves `irq_o` high.
- R11: After reset, the status, mask, interrupt line, transmit valid and flush outputs are all zero, and the tick count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| tick_i | input | 1 | Periodic tick pulse |
| rx_arrive_i | input | 2 | Character arrival event per channel |
| rx_avail_i | input | 2 | Character available level per channel |
| rx_data_a_i | input | 8 | Received byte, channel A |
| rx_data_b_i | input | 8 | Received byte, channel B |
| rx_pop_o | output | 2 | Received byte consumed, per channel |
| tx_valid_o | output | 2 | Transmit byte valid pulse, per channel |
| tx_data_o | output | 8 | Transmit byte |
| flush_o | output | 2 | Output flush request pulse, per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The interrupt line has one clear source and several set sources, so the collision that matters is a status A read landing in the same cycle as a masked character arrival or an even tick. The same holds for a holding-register access landing on a bit that is being set. Random traffic drives the tick and arrival inputs independently of bus accesses, so these overlaps occur often. Directed cycles also force each overlap once. A bench model applies clear-then-set and set-wins-over-drop, and every cycle's `irq_o` and status readback are compared with it.

// File: rtl/duart_fe_pkg.sv
package duart_fe_pkg;
  localparam int NCH     = 2;
  localparam int DW      = 8;
  localparam int CH_BITS = 4;   // status/mask bit stride between channels
  localparam int TX_POS  = 0;   // offset within a channel's nibble
  localparam int RX_POS  = 1;
  localparam int ST_RX   = 0;   // channel status register bits
  localparam int ST_TX   = 2;
  localparam int CMD_FLUSH = 3;

  localparam logic [DW-1:0] TX_MASK = 8'h11;
  localparam logic [DW-1:0] RX_MASK = 8'h22;

  typedef struct packed {
    logic [NCH-1:0] stat_rd;
    logic [NCH-1:0] hold_rd;
    logic [NCH-1:0] hold_wr;
    logic [NCH-1:0] cmd_wr;
    logic           isr_rd;
    logic           isr_wr;
  } dec_t;
endpackage

// File: rtl/duart_fe_dec.sv
module duart_fe_dec
  import duart_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_CMD  = 'h14,
  parameter logic [ADDR_W-1:0] OFS_HOLD = 'h1C,
  parameter logic [ADDR_W-1:0] OFS_ISR  = 'h2C,
  parameter logic [ADDR_W-1:0] CH_STEP  = 'h40
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic rd, wr;
  logic [NCH-1:0] stat_hit, cmd_hit, hold_hit;

  assign rd = req_i && !we_i;
  assign wr = req_i && we_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * int'(CH_STEP));
    assign stat_hit[c] = (addr_i == OFS_STAT + BASE);
    assign cmd_hit[c]  = (addr_i == OFS_CMD  + BASE);
    assign hold_hit[c] = (addr_i == OFS_HOLD + BASE);
  end

  always_comb begin
    dec_o.stat_rd = stat_hit & {NCH{rd}};
    dec_o.hold_rd = hold_hit & {NCH{rd}};
    dec_o.hold_wr = hold_hit & {NCH{wr}};
    dec_o.cmd_wr  = cmd_hit  & {NCH{wr}};
    dec_o.isr_rd  = rd && (addr_i == OFS_ISR);
    dec_o.isr_wr  = wr && (addr_i == OFS_ISR);
  end
endmodule

// File: rtl/duart_fe_tick.sv
module duart_fe_tick #(
  parameter int TICK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic fire_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (fire_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/duart_fe_isr.sv
module duart_fe_isr
  import duart_fe_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  dec_t           dec_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NCH-1:0] rx_arrive_i,
  input  logic           fire_i,
  output logic [DW-1:0]  isr_o,
  output logic [DW-1:0]  imr_o,
  output logic           irq_o
);
  logic [DW-1:0] isr_q, imr_q, clr, cand, set;
  logic irq_q;

  always_comb begin
    clr  = '0;
    cand = '0;
    for (int c = 0; c < NCH; c++) begin
      clr[c*CH_BITS + RX_POS]  = dec_i.hold_rd[c];
      clr[c*CH_BITS + TX_POS]  = dec_i.hold_wr[c];
      cand[c*CH_BITS + RX_POS] = rx_arrive_i[c];
    end
    set = (cand & imr_q) | ((fire_i && |(imr_q & TX_MASK)) ? TX_MASK : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      imr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~clr) | set;   // set wins
      if (dec_i.isr_wr) imr_q <= wdata_i;
      if (|set)                 irq_q <= 1'b1;
      else if (dec_i.stat_rd[0]) irq_q <= 1'b0;
    end
  end

  assign isr_o = isr_q;
  assign imr_o = imr_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/duart_irq_fe.sv
module duart_irq_fe
  import duart_fe_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int TICK_DIV = 2,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_CMD  = 'h14,
  parameter logic [ADDR_W-1:0] OFS_HOLD = 'h1C,
  parameter logic [ADDR_W-1:0] OFS_ISR  = 'h2C,
  parameter logic [ADDR_W-1:0] CH_STEP  = 'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              tick_i,
  input  logic [NCH-1:0]    rx_arrive_i,
  input  logic [NCH-1:0]    rx_avail_i,
  input  logic [DW-1:0]     rx_data_a_i,
  input  logic [DW-1:0]     rx_data_b_i,
  output logic [NCH-1:0]    rx_pop_o,
  output logic [NCH-1:0]    tx_valid_o,
  output logic [DW-1:0]     tx_data_o,
  output logic [NCH-1:0]    flush_o,
  output logic              irq_o
);
  dec_t          dec;
  logic          fire;
  logic [DW-1:0] isr_q, imr_q;
  logic [DW-1:0] rx_data [NCH];
  logic [NCH-1:0] tx_valid_q, flush_q;
  logic [DW-1:0] tx_data_q;

  assign rx_data[0] = rx_data_a_i;
  assign rx_data[1] = rx_data_b_i;

  duart_fe_dec #(
    .ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT), .OFS_CMD(OFS_CMD),
    .OFS_HOLD(OFS_HOLD), .OFS_ISR(OFS_ISR), .CH_STEP(CH_STEP)
  ) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .dec_o(dec)
  );

  duart_fe_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .fire_o(fire)
  );

  duart_fe_isr u_isr (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(dec), .wdata_i(wdata_i),
    .rx_arrive_i(rx_arrive_i), .fire_i(fire),
    .isr_o(isr_q), .imr_o(imr_q), .irq_o(irq_o)
  );

  // unmatched offsets (mode, aux, output port) fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (dec.stat_rd[c])
        rdata_o = (DW'(rx_avail_i[c]) << ST_RX) | (DW'(1) << ST_TX);
      if (dec.hold_rd[c])
        rdata_o = rx_data[c];
    end
    if (dec.isr_rd) rdata_o = isr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= '0;
      tx_data_q  <= '0;
      flush_q    <= '0;
    end else begin
      tx_valid_q <= dec.hold_wr;
      if (|dec.hold_wr) tx_data_q <= wdata_i;
      flush_q <= dec.cmd_wr & {NCH{wdata_i[CMD_FLUSH]}};
    end
  end

  assign rx_pop_o   = dec.hold_rd;
  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
  assign flush_o    = flush_q;
endmodule

// File: rtl/duart_irq_fe_chk.sv
module duart_irq_fe_chk
  import duart_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_CMD  = 'h14,
  parameter logic [ADDR_W-1:0] OFS_HOLD = 'h1C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_i,
  input logic [NCH-1:0]    rx_arrive_i,
  input logic [NCH-1:0]    flush_i,
  input logic              irq_i,
  input logic [DW-1:0]     isr_i,
  input logic [DW-1:0]     imr_i
);
  logic stat_a_rd, hold_a_rd, cmd_a_wr;
  assign stat_a_rd = req_i && !we_i && (addr_i == OFS_STAT);
  assign hold_a_rd = req_i && !we_i && (addr_i == OFS_HOLD);
  assign cmd_a_wr  = req_i && we_i && (addr_i == OFS_CMD);

  AST_ISR_LAYOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_i & ~(TX_MASK | RX_MASK)) == '0);                                  // R1
  AST_RX_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_arrive_i[0] && imr_i[1] |=> isr_i[1] && irq_i);                      // R2
  AST_STAT_TX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_a_rd |-> rdata_i[ST_TX]);                                          // R3
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !stat_a_rd |=> irq_i);                                         // R4
  AST_HOLD_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_a_rd && !rx_arrive_i[0] |=> !isr_i[1]);                            // R6
  AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_a_wr && wdata_i[CMD_FLUSH] |=> flush_i[0]);                         // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_a_rd && rx_arrive_i[0] && imr_i[1] |=> irq_i);                     // R10
endmodule

bind duart_irq_fe duart_irq_fe_chk #(
  .ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT), .OFS_CMD(OFS_CMD), .OFS_HOLD(OFS_HOLD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_i(rdata_o),
  .rx_arrive_i(rx_arrive_i), .flush_i(flush_o), .irq_i(irq_o),
  .isr_i(isr_q), .imr_i(imr_q)
);

// File: tb/tb_duart_irq_fe.sv
module tb_duart_irq_fe;
  localparam logic [7:0] A_MODE_A = 8'h04, A_STAT_A = 8'h0C, A_CMD_A = 8'h14,
                         A_HOLD_A = 8'h1C, A_AUX = 8'h24, A_ISR = 8'h2C,
                         A_MODE_B = 8'h44, A_STAT_B = 8'h4C, A_CMD_B = 8'h54,
                         A_HOLD_B = 8'h5C, A_OPCR = 8'h6C, A_OPSET = 8'h74,
                         A_OPCLR = 8'h7C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, tick = 0;
  logic [7:0] addr = 0, wdata = 0, rxa = 0, rxb = 0;
  logic [1:0] arrive = 0, avail = 0;
  logic [7:0] rdata, txd;
  logic [1:0] pop, txv, fl;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_isr, m_imr, m_txd;
  logic m_irq, m_seq;
  logic [1:0] m_txv, m_fl;

  always #2 clk = ~clk;

  duart_irq_fe dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .rx_arrive_i(arrive),
    .rx_avail_i(avail), .rx_data_a_i(rxa), .rx_data_b_i(rxb), .rx_pop_o(pop),
    .tx_valid_o(txv), .tx_data_o(txd), .flush_o(fl), .irq_o(irq)
  );

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      A_STAT_A: return {5'b0, 1'b1, 1'b0, avail[0]};
      A_STAT_B: return {5'b0, 1'b1, 1'b0, avail[1]};
      A_HOLD_A: return rxa;
      A_HOLD_B: return rxb;
      A_ISR:    return m_isr;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    case (a)
      A_STAT_A, A_STAT_B: return "R3";
      A_HOLD_A, A_HOLD_B: return "R6";
      A_ISR:              return "R1";
      default:            return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_isr = 0; m_imr = 0; m_irq = 0; m_seq = 0; m_txv = 0; m_txd = 0; m_fl = 0;
  endtask

  task automatic model_step();
    logic rd, wr;
    logic [7:0] clr, set;
    rd = req && !we; wr = req && we;
    clr = 0; set = 0;
    if (rd && addr == A_HOLD_A) clr[1] = 1;
    if (rd && addr == A_HOLD_B) clr[5] = 1;
    if (wr && addr == A_HOLD_A) clr[0] = 1;
    if (wr && addr == A_HOLD_B) clr[4] = 1;
    if (arrive[0] && m_imr[1]) set[1] = 1;
    if (arrive[1] && m_imr[5]) set[5] = 1;
    if (tick && m_seq && (m_imr[0] || m_imr[4])) set = set | 8'h11;
    if (set != 0) m_irq = 1;
    else if (rd && addr == A_STAT_A) m_irq = 0;
    m_isr = (m_isr & ~clr) | set;
    if (wr && addr == A_ISR) m_imr = wdata;
    if (tick) m_seq = !m_seq;
    m_txv = {wr && addr == A_HOLD_B, wr && addr == A_HOLD_A};
    if (m_txv != 0) m_txd = wdata;
    m_fl = {wr && addr == A_CMD_B && wdata[3], wr && addr == A_CMD_A && wdata[3]};
  endtask

  task automatic cyc(logic rq, logic w, logic [7:0] a, logic [7:0] d,
                     logic tk, logic [1:0] arr, logic [1:0] av);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d; tick = tk; arrive = arr; avail = av;
    rxa = 8'($urandom); rxb = 8'($urandom);
    #1;
    if (rq && !w) chk(rd_tag(a), "rdata", rdata, exp_rd(a));
    chk("R6", "rx_pop", {6'b0, pop},
        {6'b0, rq && !w && a == A_HOLD_B, rq && !w && a == A_HOLD_A});
    @(posedge clk);
    model_step();
    #1;
    chk("R4", "irq", {7'b0, irq}, {7'b0, m_irq});
    chk("R7", "tx_valid", {6'b0, txv}, {6'b0, m_txv});
    if (m_txv != 0) chk("R7", "tx_data", txd, m_txd);
    chk("R8", "flush", {6'b0, fl}, {6'b0, m_fl});
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 2'b00, 2'b00); endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pick [13];
    void'($urandom(32'd2718));
    pick = '{A_MODE_A, A_STAT_A, A_CMD_A, A_HOLD_A, A_AUX, A_ISR, A_MODE_B,
             A_STAT_B, A_CMD_B, A_HOLD_B, A_OPCR, A_OPSET, A_OPCLR};
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "irq at reset", {7'b0, irq}, 8'h00);
    chk("R11", "tx_valid at reset", {6'b0, txv}, 8'h00);
    chk("R11", "flush at reset", {6'b0, fl}, 8'h00);
    rst_n = 1'b1;
    cyc(1, 0, A_ISR, 0, 0, 0, 0);                  // R11 status zero

    // R2 masked arrival on A
    cyc(1, 1, A_ISR, 8'h22, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 2'b01, 0);
    chk("R2", "irq after masked arrival", {7'b0, irq}, 8'h01);
    cyc(1, 0, A_ISR, 0, 0, 0, 0);
    // R4 status B read keeps irq, status A read drops it
    cyc(1, 0, A_STAT_B, 0, 0, 0, 2'b10);
    chk("R4", "irq after status B read", {7'b0, irq}, 8'h01);
    cyc(1, 0, A_STAT_A, 0, 0, 0, 2'b01);
    chk("R4", "irq after status A read", {7'b0, irq}, 8'h00);
    // R10 set in same cycle as status A read
    cyc(1, 0, A_STAT_A, 0, 0, 2'b10, 0);
    chk("R10", "irq set-wins", {7'b0, irq}, 8'h01);
    // R6 holding read clears RX bit; R10 same-cycle arrival keeps it
    cyc(1, 0, A_HOLD_B, 0, 0, 0, 0);
    cyc(1, 0, A_HOLD_A, 0, 0, 2'b01, 0);
    cyc(1, 0, A_ISR, 0, 0, 0, 0);
    // R2 unmasked arrival ignored
    cyc(1, 1, A_ISR, 8'h00, 0, 0, 0);
    cyc(1, 0, A_HOLD_A, 0, 0, 0, 0);
    cyc(1, 0, A_STAT_A, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 2'b11, 0);
    chk("R2", "irq after unmasked arrival", {7'b0, irq}, 8'h00);
    cyc(1, 0, A_ISR, 0, 0, 0, 0);
    // R5 tick pairing with only B's TX mask set
    cyc(1, 1, A_ISR, 8'h10, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R5", "irq after odd tick", {7'b0, irq}, 8'h00);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R5", "irq after even tick", {7'b0, irq}, 8'h01);
    cyc(1, 0, A_ISR, 0, 0, 0, 0);
    // R7 holding write A clears only bit 0
    cyc(1, 1, A_HOLD_A, 8'h5A, 0, 0, 0);
    chk("R7", "tx_valid A", {6'b0, txv}, 8'h01);
    chk("R7", "tx_data A", txd, 8'h5A);
    cyc(1, 0, A_ISR, 0, 0, 0, 0);
    // R8 flush on bit 3 only
    cyc(1, 1, A_CMD_B, 8'h08, 0, 0, 0);
    chk("R8", "flush B", {6'b0, fl}, 8'h02);
    cyc(1, 1, A_CMD_A, 8'hF7, 0, 0, 0);
    chk("R8", "no flush", {6'b0, fl}, 8'h00);
    // R9 ignored registers
    cyc(1, 1, A_MODE_A, 8'hFF, 0, 0, 0);
    cyc(1, 1, A_OPSET, 8'hFF, 0, 0, 0);
    cyc(1, 0, A_MODE_A, 0, 0, 0, 0);
    cyc(1, 0, A_AUX, 0, 0, 0, 0);
    cyc(1, 0, A_ISR, 0, 0, 0, 0);
    chk("R9", "irq after ignored writes", {7'b0, irq}, {7'b0, m_irq});

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic rq, w;
      logic [7:0] a, d;
      rq = ($urandom % 4) != 0;
      w  = $urandom % 2;
      a  = pick[$urandom % 13];
      d  = 8'($urandom);
      cyc(rq, w, a, d, ($urandom % 3) == 0, 2'($urandom % 4) & 2'($urandom % 4),
          2'($urandom));
    end

    // R11 reset mid-run
    @(negedge clk);
    req = 0; tick = 0; arrive = 0;
    rst_n = 1'b0;
    #1;
    chk("R11", "irq in reset", {7'b0, irq}, 8'h00);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, A_ISR, 0, 0, 0, 0);
    cyc(1, 1, A_ISR, 8'h01, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R11", "tick count restarted", {7'b0, irq}, 8'h00);
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule